// File: doc/BRIEF.md
# Encoded Reference Divider

This block divides a reference clock down to the phase-comparison rate of a frequency synthesizer. A 5-bit selector picks the division ratio. The upper two bits choose a base factor of 1, 5, 6 or 7, and the lower three bits choose a power-of-two multiplier. This gives 29 legal ratios from 2 to 448. The remaining three codes are illegal and have no ratio.

The block counts reference cycles. It emits a one-cycle comparison pulse at the last cycle of every period. It also drives a square-wave copy of the comparison rate, meant for a test observation pin.

A new selector value is only sampled at a period boundary, so the period in progress always completes at its old length. An illegal selector raises a flag and is never adopted: the last legal ratio stays in force.

Top module: `cmp_ratio_div`

## Requirements
- R1: While `rst_n` is low, `cmp_pulse` is 0 and the active ratio is 2. The first `cmp_pulse` appears in the second clock cycle after `rst_n` rises.
- R2: `cmp_pulse` is high for exactly one cycle per period. A period lasts N clock cycles, where N is the active ratio.
- R3: For selector bits [4:3] = 00 and bits [2:0] = k, the ratio is 2^(k+1), giving 2 to 256.
- R4: For bits [4:3] = 01 and k >= 1, the ratio is 5*2^(k-1), giving 5 to 320.
- R5: For bits [4:3] = 10 and k >= 1, the ratio is 6*2^(k-1), giving 6 to 384.
- R6: For bits [4:3] = 11 and k >= 1, the ratio is 7*2^(k-1), giving 7 to 448.
- R7: `bad_sel` is high, combinationally, exactly when the selector is 01000, 10000 or 11000. It is low for every other code.
- R8: If the selector is illegal at a period boundary, the active ratio is kept unchanged.
- R9: The selector is sampled only on the clock edge that ends a period (the edge at which `cmp_pulse` is high). The period in progress keeps its length.
- R10: `cmp_half` is high for the first floor(N/2) cycles of each period and low for the remaining cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 5 | Encoded division-ratio selector |
| cmp_pulse | output | 1 | One-cycle pulse at the end of each comparison period |
| cmp_half | output | 1 | Square-wave version of the comparison rate |
| bad_sel | output | 1 | Selector currently holds an illegal code |

## Verification
The hardest situation to reach is a selector change that lands in the middle of a long period. A correct design must let the old period run to its full length before the new ratio applies. A design that samples the selector too early gives a visibly shorter period, but only if the change arrives well before the boundary.

The stimulus sets up a 256-cycle period, switches to the 2-cycle code a few cycles after the boundary, and measures both the period in flight and the one after it. Illegal codes are applied right after legal ones of different lengths. This shows that the held ratio is the previous one and not a reset value.

// File: rtl/cmp_ratio_div.sv
module cmp_ratio_div #(
  parameter int RATIO_W   = 9,
  parameter int RST_RATIO = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] ratio_sel,
  output logic       cmp_pulse,
  output logic       cmp_half,
  output logic       bad_sel
);

  logic [RATIO_W-1:0] cnt, cur_ratio, dec_ratio;
  logic [2:0]         k, sh;
  logic               illegal, last;

  assign k       = ratio_sel[2:0];
  assign sh      = k - 3'd1;
  assign illegal = (ratio_sel[4:3] != 2'b00) && (k == 3'd0);

  always_comb begin
    case (ratio_sel[4:3])
      2'b00:   dec_ratio = RATIO_W'(2) << k;
      2'b01:   dec_ratio = RATIO_W'(5) << sh;
      2'b10:   dec_ratio = RATIO_W'(6) << sh;
      default: dec_ratio = RATIO_W'(7) << sh;
    endcase
  end

  assign last = (cnt == cur_ratio - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      cur_ratio <= RATIO_W'(RST_RATIO);
    end else if (last) begin
      cnt <= '0;
      if (!illegal) cur_ratio <= dec_ratio;
    end else begin
      cnt <= cnt + RATIO_W'(1);
    end
  end

  assign cmp_pulse = last;
  assign cmp_half  = cnt < (cur_ratio >> 1);
  assign bad_sel   = illegal;

endmodule

// File: rtl/cmp_ratio_div_chk.sv
module cmp_ratio_div_chk #(
  parameter int RATIO_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmp_pulse,
  input logic               cmp_half,
  input logic               bad_sel,
  input logic [RATIO_W-1:0] cur_ratio
);

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  // R10
  half_low_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> !cmp_half);

  // R10
  half_rise_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_half) |-> $past(cmp_pulse));

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_pulse && bad_sel) |=> $stable(cur_ratio));

  // R9
  ratio_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_pulse |=> $stable(cur_ratio));

endmodule

bind cmp_ratio_div cmp_ratio_div_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_pulse(cmp_pulse),
  .cmp_half(cmp_half), .bad_sel(bad_sel), .cur_ratio(cur_ratio)
);

// File: tb/sim_cmp_ratio_div.sv
module sim_cmp_ratio_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] ratio_sel = 5'd0;
  logic       cmp_pulse, cmp_half, bad_sel;

  int vectors = 0;
  int fails = 0;
  int m_cnt = 0;
  int m_ratio = 2;
  bit live = 1'b0;
  bit done = 1'b0;
  int last_good = 2;

  always #4 clk = ~clk;

  cmp_ratio_div u0 (.clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
                    .cmp_pulse(cmp_pulse), .cmp_half(cmp_half), .bad_sel(bad_sel));

  function automatic int exp_ratio(logic [4:0] c);
    int k = int'(c[2:0]);
    int base;
    if (c[4:3] == 2'b00) return 2 ** (k + 1);
    if (k == 0) return 0;
    base = (c[4:3] == 2'b01) ? 5 : (c[4:3] == 2'b10) ? 6 : 7;
    return base * (2 ** (k - 1));
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ratio = 2;
    end else if (m_cnt == m_ratio - 1) begin
      m_cnt = 0;
      if (exp_ratio(ratio_sel) != 0) m_ratio = exp_ratio(ratio_sel);
    end else begin
      m_cnt++;
    end
  end

  always @(negedge clk) begin
    #1;
    if (live && !done) begin
      chk("R2 pulse", int'(cmp_pulse), int'(m_cnt == m_ratio - 1));
      chk("R10 half", int'(cmp_half), int'(m_cnt < m_ratio / 2));
      chk("R7 bad_sel", int'(bad_sel), int'(exp_ratio(ratio_sel) == 0));
    end
  end

  task automatic period_after(logic [4:0] c, output int n);
    ratio_sel = c;
    #1;
    while (!cmp_pulse) begin @(negedge clk); #1; end
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!cmp_pulse);
  endtask

  task automatic run_code(logic [4:0] c);
    int n, e;
    string tag;
    period_after(c, n);
    e = exp_ratio(c);
    case (c[4:3])
      2'b00: tag = "R3";
      2'b01: tag = "R4";
      2'b10: tag = "R5";
      default: tag = "R6";
    endcase
    if (e == 0) chk("R8 illegal holds ratio", n, last_good);
    else begin
      chk(tag, n, e);
      last_good = e;
    end
  endtask

  initial begin
    int seed;
    int n;
    seed = $urandom(32'h1D2C);
    repeat (3) @(negedge clk);
    #1;
    // R1
    chk("R1 pulse in reset", int'(cmp_pulse), 0);
    chk("R1 half in reset", int'(cmp_half), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    chk("R1 first pulse", int'(cmp_pulse), 1);
    chk("R1 half at first pulse", int'(cmp_half), 0);
    live = 1'b1;

    for (int c = 0; c < 32; c++) run_code(5'(c));

    run_code(5'b11111);
    run_code(5'b01000);
    run_code(5'b00011);
    run_code(5'b10000);
    run_code(5'b11000);

    for (int i = 0; i < 40; i++) run_code(5'($urandom % 32));

    // R9: change the selector a few cycles into a 256-cycle period
    run_code(5'b00111);
    n = 0;
    do begin
      @(negedge clk); #1; n++;
      if (n == 5) ratio_sel = 5'b00000;
    end while (!cmp_pulse);
    chk("R9 period in flight", n, 256);
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!cmp_pulse);
    chk("R9 new ratio", n, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule